// File: doc/BRIEF.md
# Ascending Block Transfer Sequencer

This block executes the compressed-encoding block load and block store instructions that use an increment-after address. It takes a 16-bit instruction word with an 8-bit register list, a 3-bit base register field and a direction bit. It reads the base register and then steps through the list from the lowest index upward. For each selected register it issues one word-wide memory access and raises the address by one word. At the end it writes the stepped address back into the base register.

It also reports the cycle cost of the instruction. The cost is built from weighted nonsequential, sequential and internal cycle units, and loads and stores use different formulas. The register file is outside the block and is reached through one combinational read port and one write port. Memory is reached through a request that is held until it is acknowledged, so wait states of any length are tolerated.

Top module: `blkx_seq`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low and only when instruction bits 15:12 equal 1100. Any other opcode, and any `start` seen while `busy` is high, causes no memory access and no register write.
- R2: Instruction bit 11 picks the direction: 0 means store (memory is written from registers) and 1 means load (registers are written from memory). Bits 10:8 name the base register and bits 7:0 are the register list, where bit i selects register i.
- R3: Registers are transferred in ascending index order, from 0 to 7. Only registers whose list bit is set are transferred, with exactly one word access each.
- R4: The first access uses the value the base register held at acceptance. Each later access uses an address 4 higher than the one before.
- R5: In the final cycle `done` pulses for one cycle. In that same cycle the base register is written with the base value plus 4 times the number of listed registers.
- R6: For a store of k registers, `cyc_count` at `done` equals 2·N + k·S − S. The defaults are N=2, S=1 and I=1.
- R7: For a load of k registers, `cyc_count` at `done` equals N + I + k·S.
- R8: An empty list makes no memory access and writes the base register back with its unchanged value.
- R9: In a load whose list holds the base register, the base register ends up holding the stepped address and not the loaded word.
- R10: `busy` rises in the cycle after acceptance and stays high through the `done` cycle. A memory request is held with a stable address until `mem_ack` arrives.
- R11: During a load, the word returned with `mem_ack` is written into the register that is being transferred, in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run `instr` |
| instr | input | 16 | Instruction word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse in the writeback cycle |
| cyc_count | output | 8 | Cycle cost of the instruction, valid at `done` |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Memory acknowledge, completes the access |
| mem_rdata | input | 32 | Load data, valid with `mem_ack` |

## Verification
The bench builds the block with its default parameters: eight registers, 32-bit words and cost weights N=2, S=1, I=1. Because the N and S weights differ, a wrong unit in either cost formula changes `cyc_count`. With the full list width of eight bits, the tests can use sparse lists, an empty list and a list that contains the base register. Memory answers with zero or two wait states, which exercises how the request is held while an acknowledge is pending.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_WBACK = 2'd2
  } xstate_t;
endpackage

// File: rtl/blkx_pick.sv
// Selects the lowest set bit of a vector and returns its index and the
// vector with that bit cleared.
module blkx_pick #(
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic [NREG-1:0] vec,
  output logic [RIW-1:0]  idx,
  output logic [NREG-1:0] rest
);
  logic [NREG:0]   none_below;
  logic [NREG-1:0] sel;

  assign none_below[0] = 1'b1;
  for (genvar i = 0; i < NREG; i++) begin : g_chain
    assign sel[i]          = vec[i] & none_below[i];
    assign none_below[i+1] = none_below[i] & ~vec[i];
  end

  always_comb begin
    idx = '0;
    for (int j = 0; j < NREG; j++) begin
      if (sel[j]) idx = idx | RIW'(j);
    end
  end

  assign rest = vec & ~sel;
endmodule

// File: rtl/blkx_popcnt.sv
module blkx_popcnt #(
  parameter int NREG = 8,
  localparam int PW = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] vec,
  output logic [PW-1:0]   cnt
);
  always_comb begin
    cnt = '0;
    for (int j = 0; j < NREG; j++) begin
      cnt = cnt + PW'(vec[j]);
    end
  end
endmodule

// File: rtl/blkx_cost.sv
// Cycle cost: store = 2N + kS - S, load = N + I + kS.
module blkx_cost #(
  parameter int NREG  = 8,
  parameter int CW    = 8,
  parameter int CYC_N = 2,
  parameter int CYC_S = 1,
  parameter int CYC_I = 1,
  localparam int PW = $clog2(NREG + 1)
) (
  input  logic [PW-1:0] cnt,
  input  logic          is_load,
  output logic [CW-1:0] cycles
);
  logic [CW-1:0] per_reg;

  assign per_reg = CW'(cnt) * CW'(CYC_S);

  always_comb begin
    if (is_load) cycles = CW'(CYC_N) + CW'(CYC_I) + per_reg;
    else         cycles = CW'(2 * CYC_N) + per_reg - CW'(CYC_S);
  end
endmodule

// File: rtl/blkx_seq.sv
module blkx_seq #(
  parameter int NREG   = 8,
  parameter int DW     = 32,
  parameter int AW     = 32,
  parameter int IW     = 16,
  parameter int CW     = 8,
  parameter int OPCODE = 12,
  parameter int CYC_N  = 2,
  parameter int CYC_S  = 1,
  parameter int CYC_I  = 1,
  localparam int RIW   = $clog2(NREG),
  localparam int PW    = $clog2(NREG + 1),
  localparam int DIRB  = NREG + RIW,
  localparam int OPL   = DIRB + 1,
  localparam int OPW   = IW - OPL,
  localparam int STEP  = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [IW-1:0]  instr,
  output logic           busy,
  output logic           done,
  output logic [CW-1:0]  cyc_count,
  output logic [RIW-1:0] rf_raddr,
  input  logic [DW-1:0]  rf_rdata,
  output logic           rf_we,
  output logic [RIW-1:0] rf_waddr,
  output logic [DW-1:0]  rf_wdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata
);
  import blkx_pkg::*;

  xstate_t        state_q, state_d;
  logic [NREG-1:0] pend_q, pend_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [RIW-1:0] base_q, base_d;
  logic           load_q, load_d;
  logic [CW-1:0]  cyc_q, cyc_d;

  logic [NREG-1:0] in_list;
  logic [RIW-1:0]  in_base;
  logic            in_load;
  logic            accept;
  logic [PW-1:0]   list_cnt;
  logic [CW-1:0]   list_cost;
  logic [RIW-1:0]  cur_idx;
  logic [NREG-1:0] pend_rest;
  logic            beat_done;

  assign in_list = instr[NREG-1:0];
  assign in_base = instr[DIRB-1:NREG];
  assign in_load = instr[DIRB];
  assign accept  = (state_q == ST_IDLE) && start && (instr[IW-1:OPL] == OPW'(OPCODE));

  blkx_popcnt #(.NREG(NREG)) u_popcnt (
    .vec (in_list),
    .cnt (list_cnt)
  );

  blkx_cost #(
    .NREG(NREG), .CW(CW), .CYC_N(CYC_N), .CYC_S(CYC_S), .CYC_I(CYC_I)
  ) u_cost (
    .cnt     (list_cnt),
    .is_load (in_load),
    .cycles  (list_cost)
  );

  blkx_pick #(.NREG(NREG)) u_pick (
    .vec  (pend_q),
    .idx  (cur_idx),
    .rest (pend_rest)
  );

  assign beat_done = (state_q == ST_XFER) && mem_ack;

  // next-state logic
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    addr_d  = addr_q;
    base_d  = base_q;
    load_d  = load_q;
    cyc_d   = cyc_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          pend_d  = in_list;
          addr_d  = AW'(rf_rdata);
          base_d  = in_base;
          load_d  = in_load;
          cyc_d   = list_cost;
          state_d = (in_list == '0) ? ST_WBACK : ST_XFER;
        end
      end
      ST_XFER: begin
        if (mem_ack) begin
          pend_d = pend_rest;
          addr_d = addr_q + AW'(STEP);
          if (pend_rest == '0) state_d = ST_WBACK;
        end
      end
      ST_WBACK: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      base_q  <= '0;
      load_q  <= 1'b0;
      cyc_q   <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      addr_q  <= addr_d;
      base_q  <= base_d;
      load_q  <= load_d;
      cyc_q   <= cyc_d;
    end
  end

  // outputs
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_WBACK);
  assign cyc_count = cyc_q;

  assign rf_raddr  = (state_q == ST_IDLE) ? in_base : cur_idx;
  assign rf_we     = done || (beat_done && load_q);
  assign rf_waddr  = done ? base_q : cur_idx;
  assign rf_wdata  = done ? DW'(addr_q) : mem_rdata;

  assign mem_req   = (state_q == ST_XFER);
  assign mem_we    = ~load_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = rf_rdata;
endmodule

// File: rtl/blkx_seq_chk.sv
module blkx_seq_chk #(
  parameter int IW = 16,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [IW-1:0] instr,
  input logic          busy,
  input logic          done,
  input logic          rf_we,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack
);
  // R1: a matching start while idle raises busy next cycle
  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && instr[IW-1:IW-4] == 4'b1100) |=> busy);

  // R1: a non-matching opcode seen while idle is ignored
  assert_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(start && instr[IW-1:IW-4] == 4'b1100)) |=> !busy);

  // R10: memory requests only while busy
  assert_req_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R10: pending request held with stable address and direction
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4: consecutive accesses step by one word
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (!mem_req || mem_addr == $past(mem_addr) + AW'(4)));

  // R5: done ends the sequence after one cycle
  assert_done_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R5 / R11: register writes only at writeback or on a load beat
  assert_rf_we_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (done || (mem_req && mem_ack && !mem_we)));
endmodule

bind blkx_seq blkx_seq_chk #(.IW(IW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .instr    (instr),
  .busy     (busy),
  .done     (done),
  .rf_we    (rf_we),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack)
);

// File: tb/blkx_seq_tb.sv
`timescale 1ns/1ps
module blkx_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic        busy, done;
  logic [7:0]  cyc_count;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  blkx_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .busy(busy), .done(done), .cyc_count(cyc_count),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // bench models of the register file and memory
  logic [31:0] rf [8];
  logic [31:0] mem [64];
  logic        pre_rf_we = 1'b0, pre_mem_we = 1'b0;
  logic [5:0]  pre_idx = '0;
  logic [31:0] pre_val = '0;
  int          wait_sel = 0;
  int          wcnt = 0;
  int          acc_total = 0;

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[7:2]];
  assign mem_ack   = mem_req && (wcnt == wait_sel);

  always @(posedge clk) begin
    if (pre_rf_we)  rf[pre_idx[2:0]] <= pre_val;
    if (pre_mem_we) mem[pre_idx] <= pre_val;
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (mem_req && mem_ack && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    if (mem_req && mem_ack) acc_total <= acc_total + 1;
    if (!mem_req || mem_ack) wcnt <= 0;
    else wcnt <= wcnt + 1;
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_rf(int idx, logic [31:0] v);
    @(negedge clk);
    pre_rf_we = 1'b1; pre_idx = 6'(idx); pre_val = v;
    @(negedge clk);
    pre_rf_we = 1'b0;
  endtask

  task automatic put_mem(int idx, logic [31:0] v);
    @(negedge clk);
    pre_mem_we = 1'b1; pre_idx = 6'(idx); pre_val = v;
    @(negedge clk);
    pre_mem_we = 1'b0;
  endtask

  function automatic logic [31:0] pat(int i);
    return 32'h1000_0000 + 32'(i) * 32'h111;
  endfunction

  task automatic fill_rf();
    for (int i = 0; i < 8; i++) put_rf(i, pat(i));
  endtask

  // issue one instruction, wait for done, return its cost
  task automatic run_op(logic [15:0] ins, bit inject, output logic [7:0] cost);
    int guard;
    @(negedge clk);
    instr = ins; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 busy after accept", 32'(busy), 32'd1);
    if (inject) begin
      instr = 16'hC3FF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 1000) begin
      check("R10 busy held", 32'(busy), 32'd1);
      @(negedge clk);
      guard++;
    end
    cost = cyc_count;
    @(negedge clk);
    check("R5 busy low after done", 32'(busy), 32'd0);
  endtask

  task automatic t_reset();
    check("R10 reset busy", 32'(busy), 32'd0);
    check("R10 reset mem_req", 32'(mem_req), 32'd0);
    check("R5 reset rf_we", 32'(rf_we), 32'd0);
  endtask

  task automatic t_store();
    logic [7:0] c; int a0;
    fill_rf();
    put_rf(3, 32'h40);
    put_mem(16, 32'h0); put_mem(17, 32'h0); put_mem(18, 32'h0); put_mem(19, 32'h0);
    put_mem(20, 32'hDEAD);
    wait_sel = 0;
    a0 = acc_total;
    run_op(16'hC3A5, 1'b0, c);
    check("R3 store access count", 32'(acc_total - a0), 32'd4);
    check("R3 R4 store r0 at base", mem[16], pat(0));
    check("R3 R4 store r2", mem[17], pat(2));
    check("R3 R4 store r5", mem[18], pat(5));
    check("R3 R4 store r7", mem[19], pat(7));
    check("R4 nothing past end", mem[20], 32'hDEAD);
    check("R5 store base writeback", rf[3], 32'h50);
    check("R6 store cost", 32'(c), 32'd7);
    check("R2 store leaves r5", rf[5], pat(5));
  endtask

  task automatic t_load();
    logic [7:0] c; int a0;
    fill_rf();
    put_rf(0, 32'h80);
    put_mem(32, 32'hAAAA_0001); put_mem(33, 32'hBBBB_0002); put_mem(34, 32'hCCCC_0003);
    put_mem(19, 32'h5555);
    wait_sel = 2;
    a0 = acc_total;
    run_op(16'hC852, 1'b1, c);
    check("R1 start while busy ignored", 32'(acc_total - a0), 32'd3);
    check("R1 busy start no store", mem[19], 32'h5555);
    check("R11 load r1", rf[1], 32'hAAAA_0001);
    check("R11 load r4", rf[4], 32'hBBBB_0002);
    check("R11 load r6", rf[6], 32'hCCCC_0003);
    check("R3 unlisted r2 kept", rf[2], pat(2));
    check("R5 load base writeback", rf[0], 32'h8C);
    check("R7 load cost", 32'(c), 32'd6);
    wait_sel = 0;
  endtask

  task automatic t_base_in_list();
    logic [7:0] c;
    put_rf(2, 32'hC0);
    put_mem(48, 32'h0D0D_0D0D); put_mem(49, 32'h0E0E_0E0E);
    run_op(16'hCA06, 1'b0, c);
    check("R11 load r1 before base", rf[1], 32'h0D0D_0D0D);
    check("R9 base writeback wins", rf[2], 32'hC8);
    check("R7 two-register load cost", 32'(c), 32'd5);
  endtask

  task automatic t_empty();
    logic [7:0] c; int a0;
    put_rf(5, 32'h33);
    a0 = acc_total;
    run_op(16'hC500, 1'b0, c);
    check("R8 empty store no access", 32'(acc_total - a0), 32'd0);
    check("R8 empty store base kept", rf[5], 32'h33);
    check("R6 empty store cost", 32'(c), 32'd3);
    run_op(16'hCD00, 1'b0, c);
    check("R8 empty load no access", 32'(acc_total - a0), 32'd0);
    check("R7 empty load cost", 32'(c), 32'd3);
  endtask

  task automatic t_bad_opcode();
    int a0;
    logic [31:0] r3v;
    r3v = rf[3];
    a0 = acc_total;
    @(negedge clk);
    instr = 16'hD3A5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 other opcode not busy", 32'(busy), 32'd0);
    repeat (3) @(negedge clk);
    check("R1 other opcode no access", 32'(acc_total - a0), 32'd0);
    check("R1 other opcode base kept", rf[3], r3v);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_store();
    t_load();
    t_base_in_list();
    t_empty();
    t_bad_opcode();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule